// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block sits between a processor's instruction-fetch port and a shared 16-bit memory bus. It holds a small byte queue of instruction codes and hands the CPU one byte per cycle from the head of that queue. If the CPU asks for a byte while the queue is empty, the stall output stays high until a byte is present. The controller also fetches on its own. It starts a bus fetch when the queue is empty, or when it holds a single byte and the data-access side is not going to use the bus.

Each fetch reads either a 16-bit even/odd pair or a single byte. It reads a single byte when the fetch address is odd. It also reads a single byte when the 8-bit external bus mode is on and the address lies in the external region. The two byte-lane strobes tell the memory which lanes are in use. A branch flush clears the queue, discards any fetch data still in flight and restarts fetching at the branch target. Data-side bus requests always take precedence over instruction fetches.

Top module: `ifq_ctrl`

## Requirements
- R1: When `cpu_req` is high and the queue holds no byte, `cpu_stall` is high and nothing is consumed. Bytes reach the CPU strictly in ascending address order from the current fetch start.
- R2: With no CPU consumption, a fetch is issued only when the queue is empty, or when it holds one byte and `dside_req` is low. After reset from even address 0 with the CPU idle, exactly one bus access occurs.
- R3: A fetch from an even address outside the single-byte case reads both lanes in one access: the byte at the even address from `bus_rdata[7:0]` and the next odd byte from `bus_rdata[15:8]`. Both are queued.
- R4: A fetch from an odd address queues only the byte from `bus_rdata[15:8]`. A flush to odd address 0x1235 with the CPU idle therefore results in exactly two bus accesses.
- R5: When `byte_mode` is 1 and the fetch address is at or above `EXT_BASE` (default 0x8000), each access reads one byte. An even address then takes its byte from `bus_rdata[7:0]`. Addresses below `EXT_BASE` still read pairs.
- R6: On every issued request, `bus_a0` equals address bit 0. `bus_bhe_n` is 0 exactly when the odd lane is read (odd address or pair access). A pair access therefore drives both low.
- R7: The queue never holds more than `DEPTH` (default 4) bytes, and a fetch is issued only when there is room for every byte it returns.
- R8: `flush` empties the queue in the next cycle and drops any data of a fetch granted before or during the flush cycle. The next byte delivered is the byte at `flush_addr`.
- R9: `bus_req` is low in every cycle in which `dside_req` is high. A pending fetch waits for `bus_gnt`, sampled only while `bus_req` is high.
- R10: During reset `bus_req` is low and a CPU request sees `cpu_stall` high. The first fetch after reset uses address `RESET_ADDR` (default 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU wants the next instruction byte this cycle |
| cpu_stall | output | 1 | CPU must wait: queue empty |
| cpu_byte | output | 8 | Instruction byte at the queue head |
| flush | input | 1 | Branch: clear queue and refetch from `flush_addr` |
| flush_addr | input | AW | Branch target address |
| byte_mode | input | 1 | 1 = external region uses an 8-bit bus |
| dside_req | input | 1 | Data-access side wants the bus (higher priority) |
| bus_req | output | 1 | Instruction fetch request |
| bus_gnt | input | 1 | Bus grant, taken while `bus_req` is high |
| bus_addr | output | AW | Fetch address |
| bus_a0 | output | 1 | Low-lane strobe, low for even-address access |
| bus_bhe_n | output | 1 | High-lane strobe, low when the odd byte is read |
| bus_rvalid | input | 1 | Read data of the granted fetch is valid |
| bus_rdata | input | 16 | Read data, even byte in [7:0], odd byte in [15:8] |

## Verification
Several properties are checked by assertions in every cycle: the queue depth bound, the room check at issue time, the strobe pattern of a live request, pair pushes only from even addresses, odd pushes limited to one byte, emptiness after a flush, and silence of `bus_req` under a data-side request. Other behaviour can only be shown by the bench's scenarios. This covers byte order and lane selection as seen by the CPU, and how many accesses the prefetch condition actually triggers from a given start address and bus mode. It also covers dropping in-flight data on a flush, because each of these depends on sequences spanning several fetches.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_DATA = 2'd2
    } fetch_state_e;
endpackage

// File: rtl/ifq_bytes.sv
// Byte queue: up to two bytes pushed and one popped per cycle.
// DEPTH must be a power of two so the pointers wrap naturally.
module ifq_bytes #(
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [1:0]      push_cnt,
    input  logic [7:0]      push_b0,
    input  logic [7:0]      push_b1,
    input  logic            pop,
    output logic [7:0]      head,
    output logic [CNTW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PW-1:0]         rd;
        logic [PW-1:0]         wr;
        logic [CNTW-1:0]       cnt;
    } qst_t;

    qst_t q_q, q_d;
    logic [PW-1:0] wr1;

    always_comb begin
        q_d = q_q;
        wr1 = q_q.wr + 1'b1;
        if (clr) begin
            q_d.rd  = '0;
            q_d.wr  = '0;
            q_d.cnt = '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (push_cnt != 2'd0 && q_q.wr == PW'(i)) q_d.mem[i] = push_b0;
                if (push_cnt == 2'd2 && wr1 == PW'(i))    q_d.mem[i] = push_b1;
            end
            q_d.wr  = q_q.wr + PW'(push_cnt);
            q_d.rd  = q_q.rd + PW'(pop);
            q_d.cnt = q_q.cnt + CNTW'(push_cnt) - CNTW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head  = q_q.mem[q_q.rd];
    assign count = q_q.cnt;

    p_depth_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.cnt <= CNTW'(DEPTH));
    p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q_q.cnt == '0));
endmodule

// File: rtl/ifq_fetch.sv
// Fetch sequencer: decides when to prefetch, drives the bus request and
// strobes, and picks the byte lanes of the returning word.
module ifq_fetch
    import ifq_pkg::*;
#(
    parameter int             AW         = 16,
    parameter int             DEPTH      = 4,
    parameter logic [AW-1:0]  RESET_ADDR = '0,
    parameter logic [AW-1:0]  EXT_BASE   = AW'(1) << (AW - 1),
    localparam int            CNTW       = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CNTW-1:0] count,
    input  logic            flush,
    input  logic [AW-1:0]   flush_addr,
    input  logic            byte_mode,
    input  logic            dside_req,
    output logic            bus_req,
    input  logic            bus_gnt,
    output logic [AW-1:0]   bus_addr,
    output logic            bus_a0,
    output logic            bus_bhe_n,
    input  logic            bus_rvalid,
    input  logic [15:0]     bus_rdata,
    output logic [1:0]      push_cnt,
    output logic [7:0]      push_b0,
    output logic [7:0]      push_b1
);
    typedef struct packed {
        fetch_state_e  st;
        logic [AW-1:0] pc;
        logic          pair;
        logic          drop;
    } fst_t;

    fst_t f_q, f_d;
    logic need_pair, starve, room, granted, take;

    always_comb begin
        need_pair = !f_q.pc[0] && !(byte_mode && (f_q.pc >= EXT_BASE));
        starve    = (count == '0) || ((count == CNTW'(1)) && !dside_req);
        room      = (int'(count) + (need_pair ? 2 : 1)) <= DEPTH;
        bus_req   = (f_q.st == FS_REQ) && !dside_req;
        granted   = bus_req && bus_gnt;
        take      = (f_q.st == FS_DATA) && bus_rvalid && !f_q.drop && !flush;

        f_d = f_q;
        unique case (f_q.st)
            FS_IDLE: begin
                if (flush)              f_d.pc = flush_addr;
                else if (starve && room) f_d.st = FS_REQ;
            end
            FS_REQ: begin
                if (granted) begin
                    f_d.st   = FS_DATA;
                    f_d.pair = need_pair;
                    f_d.drop = flush;
                end else if (flush) begin
                    f_d.st = FS_IDLE;
                end
                if (flush) f_d.pc = flush_addr;
            end
            FS_DATA: begin
                if (bus_rvalid) f_d.st = FS_IDLE;
                if (flush) begin
                    f_d.pc   = flush_addr;
                    f_d.drop = 1'b1;
                end else if (take) begin
                    f_d.pc = f_q.pc + (f_q.pair ? AW'(2) : AW'(1));
                end
            end
            default: f_d.st = FS_IDLE;
        endcase

        push_cnt = take ? (f_q.pair ? 2'd2 : 2'd1) : 2'd0;
        push_b0  = (!f_q.pair && f_q.pc[0]) ? bus_rdata[15:8] : bus_rdata[7:0];
        push_b1  = bus_rdata[15:8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: FS_IDLE, pc: RESET_ADDR, pair: 1'b0, drop: 1'b0};
        else        f_q <= f_d;
    end

    assign bus_addr  = f_q.pc;
    assign bus_a0    = f_q.pc[0];
    assign bus_bhe_n = !(f_q.pc[0] || need_pair);

    p_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == FS_REQ) |-> ((int'(count) + (need_pair ? 2 : 1)) <= DEPTH));
    p_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !(bus_a0 && bus_bhe_n));
    p_pair_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_cnt == 2'd2) |-> !bus_addr[0]);
    p_odd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_cnt != 2'd0 && bus_addr[0]) |-> (push_cnt == 2'd1));
endmodule

// File: rtl/ifq_ctrl.sv
module ifq_ctrl #(
    parameter int             AW         = 16,
    parameter int             DEPTH      = 4,
    parameter logic [AW-1:0]  RESET_ADDR = '0,
    parameter logic [AW-1:0]  EXT_BASE   = AW'(1) << (AW - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    output logic          cpu_stall,
    output logic [7:0]    cpu_byte,
    input  logic          flush,
    input  logic [AW-1:0] flush_addr,
    input  logic          byte_mode,
    input  logic          dside_req,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [AW-1:0] bus_addr,
    output logic          bus_a0,
    output logic          bus_bhe_n,
    input  logic          bus_rvalid,
    input  logic [15:0]   bus_rdata
);
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [CNTW-1:0] count;
    logic [1:0]      push_cnt;
    logic [7:0]      push_b0, push_b1;
    logic            pop;

    assign cpu_stall = cpu_req && (count == '0);
    assign pop       = cpu_req && (count != '0) && !flush;

    ifq_bytes #(.DEPTH(DEPTH)) u_bytes (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (flush),
        .push_cnt (push_cnt),
        .push_b0  (push_b0),
        .push_b1  (push_b1),
        .pop      (pop),
        .head     (cpu_byte),
        .count    (count)
    );

    ifq_fetch #(
        .AW(AW), .DEPTH(DEPTH), .RESET_ADDR(RESET_ADDR), .EXT_BASE(EXT_BASE)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .count      (count),
        .flush      (flush),
        .flush_addr (flush_addr),
        .byte_mode  (byte_mode),
        .dside_req  (dside_req),
        .bus_req    (bus_req),
        .bus_gnt    (bus_gnt),
        .bus_addr   (bus_addr),
        .bus_a0     (bus_a0),
        .bus_bhe_n  (bus_bhe_n),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata),
        .push_cnt   (push_cnt),
        .push_b0    (push_b0),
        .push_b1    (push_b1)
    );

    p_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dside_req |-> !bus_req);
endmodule

// File: tb/ifq_ctrl_test.sv
module ifq_ctrl_test;
    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, flush = 1'b0, byte_mode = 1'b0, dside_req = 1'b0;
    logic        bus_gnt = 1'b0, bus_rvalid = 1'b0;
    logic [15:0] flush_addr = '0, bus_rdata = '0;
    logic        cpu_stall, bus_req, bus_a0, bus_bhe_n;
    logic [7:0]  cpu_byte;
    logic [15:0] bus_addr;

    int total = 0, bad = 0, grants = 0;
    logic        pend = 1'b0;
    logic [15:0] pend_addr = '0, exp_addr = '0;

    always #(CLK_P / 2) clk = ~clk;

    ifq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_stall(cpu_stall),
        .cpu_byte(cpu_byte), .flush(flush), .flush_addr(flush_addr),
        .byte_mode(byte_mode), .dside_req(dside_req), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_a0(bus_a0),
        .bus_bhe_n(bus_bhe_n), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] mem_at(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    function automatic logic pair_expected(input logic [15:0] a, input logic bm);
        return !a[0] && !(bm && a >= 16'h8000);
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock cycle: drive at the falling edge, sample 1ns later.
    task automatic cycle(input logic creq, input logic dreq, input logic gnt,
                         input logic fl, input logic [15:0] fa, input logic bm);
        logic exp_bhe;
        @(negedge clk);
        bus_rvalid = pend;
        bus_rdata  = {mem_at(pend_addr | 16'h1), mem_at(pend_addr & 16'hFFFE)};
        pend       = 1'b0;
        cpu_req = creq; dside_req = dreq; bus_gnt = gnt;
        flush = fl; flush_addr = fa; byte_mode = bm;
        #1;
        if (!rst_n) return;
        if (dside_req) chk(!bus_req, "R9 bus_req under dside_req", bus_req, 0);
        if (bus_req && bus_gnt) begin
            pend = 1'b1; pend_addr = bus_addr; grants++;
            exp_bhe = !(bus_addr[0] || pair_expected(bus_addr, byte_mode));
            chk(bus_a0 == bus_addr[0], "R6 a0", bus_a0, bus_addr[0]);
            chk(bus_bhe_n == exp_bhe, "R6/R3/R4/R5 bhe_n", bus_bhe_n, exp_bhe);
        end
        if (fl) begin
            exp_addr = fa;
        end else if (creq && !cpu_stall) begin
            chk(cpu_byte == mem_at(exp_addr), "R1/R3/R4/R5/R8 byte order",
                cpu_byte, mem_at(exp_addr));
            exp_addr++;
        end
    endtask

    // Flush with the CPU idle, check the stall, then count accesses.
    task automatic flush_count(input logic [15:0] fa, input logic bm,
                               input int exp_n, input string tag);
        cycle(1'b0, 1'b0, 1'b1, 1'b1, fa, bm);
        grants = 0;
        cycle(1'b1, 1'b0, 1'b1, 1'b0, '0, bm);
        chk(cpu_stall, "R1/R8 stall after flush", cpu_stall, 1);
        for (int i = 0; i < 20; i++) cycle(1'b0, 1'b0, 1'b1, 1'b0, '0, bm);
        chk(grants == exp_n, tag, grants, exp_n);
        for (int i = 0; i < 6; i++) cycle(1'b1, 1'b0, 1'b1, 1'b0, '0, bm);
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        // R10: reset state
        cpu_req = 1'b1;
        #(CLK_P * 3);
        chk(!bus_req, "R10 bus_req in reset", bus_req, 0);
        chk(cpu_stall, "R10 stall in reset", cpu_stall, 1);
        @(negedge clk); rst_n = 1'b1; cpu_req = 1'b0;
        grants = 0; exp_addr = '0;
        // R2/R7/R10: one pair access from address 0 with CPU idle
        for (int i = 0; i < 20; i++) cycle(1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0);
        chk(grants == 1, "R2/R7 accesses after reset", grants, 1);
        for (int i = 0; i < 6; i++) cycle(1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b0);

        flush_count(16'h1235, 1'b0, 2, "R4/R2 accesses from odd target");
        flush_count(16'h2000, 1'b0, 1, "R3/R2 accesses from even target");
        flush_count(16'h8000, 1'b1, 2, "R5 byte-mode external accesses");
        flush_count(16'h0100, 1'b1, 1, "R5 byte-mode internal pairs");
        flush_count(16'h9001, 1'b0, 2, "R4 external odd, 16-bit mode");

        // R9: data side holds the bus, then releases it
        cycle(1'b0, 1'b1, 1'b1, 1'b1, 16'h3000, 1'b0);
        grants = 0;
        for (int i = 0; i < 10; i++) cycle(1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b0);
        chk(grants == 0, "R9 no fetch while dside_req", grants, 0);
        for (int i = 0; i < 10; i++) cycle(1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0);
        chk(grants == 1, "R9 fetch after release", grants, 1);
        for (int i = 0; i < 6; i++) cycle(1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b0);

        // R8: flush in the cycle the granted data returns
        cycle(1'b0, 1'b0, 1'b0, 1'b1, 16'h4000, 1'b0);
        for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        grants = 0;
        cycle(1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0);
        chk(grants == 1, "R8 stale fetch granted", grants, 1);
        cycle(1'b0, 1'b0, 1'b1, 1'b1, 16'h5002, 1'b0);
        for (int i = 0; i < 10; i++) cycle(1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b0);
        chk(exp_addr > 16'h5002, "R8 bytes delivered from target", exp_addr, 16'h5003);

        // Constrained random mix
        begin
            logic bm = 1'b0;
            for (int i = 0; i < 4000; i++) begin
                logic fl;
                if ($urandom_range(9) == 0) bm = ~bm;
                fl = ($urandom_range(49) == 0);
                cycle($urandom_range(9) < 6, $urandom_range(4) == 0,
                      $urandom_range(9) < 7, fl, 16'($urandom), bm);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule